// File: doc/BRIEF.md
# Wide-to-Narrow Bus-Matching Unpacker

This block sits between the read side of a 36-bit first-word-fall-through FIFO and an 18-bit transmit port. It takes one wide word at a time into a holding register and sends it out in pieces. In word sizing a wide word leaves as two 18-bit halves. In byte sizing it leaves as four 9-bit bytes, which are carried on the low bits of the narrow port.

Two configuration inputs choose the sizing and whether the most or the least significant piece goes first. The block captures both inputs together with the wide word it takes, so a word always leaves with the format that was in force when it was taken. The narrow side uses a valid/ready handshake. The FIFO is popped only when the holding register is empty, or in the same cycle that the final piece of the current word is accepted. The next word can therefore follow with no idle cycle.

Top module: `bus_unpacker`

## Requirements
- R1: With `cfg_byte_mode`=0, each wide word is sent as exactly two 18-bit transfers.
- R2: With `cfg_byte_mode`=1, each wide word is sent as exactly four transfers. Each transfer carries a 9-bit byte on `tx_data[8:0]`, and `tx_data[17:9]` is zero.
- R3: With `cfg_little_endian`=0, pieces leave most significant first: bits 35:18 then 17:0 in word sizing, and bits 35:27, 26:18, 17:9, 8:0 in byte sizing.
- R4: With `cfg_little_endian`=1, pieces leave least significant first: bits 17:0 then 35:18 in word sizing, and bits 8:0, 17:9, 26:18, 35:27 in byte sizing.
- R5: `src_pop` is asserted only when `src_valid`=1 and either no word is held or the final piece of the held word is accepted in that cycle. A word whose earlier pieces are still pending does not cause a pop.
- R6: While `tx_valid`=1 and `tx_ready`=0, `tx_valid` stays high and `tx_data` keeps its value on the next cycle.
- R7: The sizing and order inputs are taken only in the cycle a word is popped. A change while a word is partly sent leaves that word's remaining pieces unchanged, and the change applies to the next word.
- R8: Reset clears the piece counter and `tx_valid`. A word that was partly sent before reset is not presented again after reset.
- R9: When `tx_ready` stays high and the FIFO is never empty, `tx_valid` is high in every cycle. The first piece of a word follows the last piece of the previous word in the next cycle.
- R10: When the FIFO is empty (`src_valid`=0), `src_pop` stays low and, once the held word is finished, `tx_valid` goes low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cfg_byte_mode | input | 1 | 0 = two 18-bit halves, 1 = four 9-bit bytes |
| cfg_little_endian | input | 1 | 0 = most significant piece first, 1 = least significant first |
| src_valid | input | 1 | FIFO holds a word; `src_data` shows it |
| src_data | input | 36 | Head word of the FIFO |
| src_pop | output | 1 | Removes the head word from the FIFO at this edge |
| tx_valid | output | 1 | A piece is presented on `tx_data` |
| tx_ready | input | 1 | Receiver accepts the piece at this edge |
| tx_data | output | 18 | Current piece |

## Verification
`src_pop` is combinational, and the word it takes is presented on `tx_valid`/`tx_data` from the next cycle on. A piece accepted at one edge is replaced by the following piece at that same edge. The bench changes inputs one time unit after a rising edge and samples the outputs on the falling edge. A piece counts as received when `tx_valid` and `tx_ready` are both high at a falling edge. The bench records the cycle number of each received piece to check that pieces follow in consecutive cycles. For back-pressure, the mid-word format change and reset, it pulses `tx_ready` for exactly one cycle and waits two edges before comparing the port values and the pop count of its FIFO model.

// File: rtl/unpk_pkg.sv
package unpk_pkg;

  typedef struct packed {
    logic byte_mode;
    logic little;
  } fmt_t;

  // index of the final piece for the chosen sizing
  function automatic int last_slot(int word_pieces, int byte_pieces, logic byte_mode);
    return byte_mode ? byte_pieces - 1 : word_pieces - 1;
  endfunction

  // piece position (0 = least significant) sent at step cnt
  function automatic int slot_of(int cnt, int last, logic little);
    return little ? cnt : last - cnt;
  endfunction

endpackage

// File: rtl/unpk_ctrl.sv
module unpk_ctrl #(
  parameter int WORD_PIECES = 2,
  parameter int BYTE_PIECES = 4,
  parameter int CNT_W       = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cfg_byte_mode,
  input  logic              cfg_little_endian,
  input  logic              src_valid,
  input  logic              tx_ready,
  output logic              src_pop,
  output logic              loaded,
  output logic [CNT_W-1:0]  cnt,
  output unpk_pkg::fmt_t    fmt_q,
  output logic              piece_accept,
  output logic              last_accept
);
  logic [CNT_W-1:0] last_idx;

  always_comb begin
    last_idx     = CNT_W'(unpk_pkg::last_slot(WORD_PIECES, BYTE_PIECES, fmt_q.byte_mode));
    piece_accept = loaded & tx_ready;
    last_accept  = piece_accept & (cnt == last_idx);
    src_pop      = src_valid & (~loaded | last_accept);
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      loaded <= 1'b0;
      cnt    <= '0;
      fmt_q  <= '0;
    end else if (src_pop) begin
      loaded <= 1'b1;
      cnt    <= '0;
      fmt_q  <= '{byte_mode: cfg_byte_mode, little: cfg_little_endian};
    end else if (last_accept) begin
      loaded <= 1'b0;
      cnt    <= '0;
    end else if (piece_accept) begin
      cnt    <= cnt + 1'b1;
    end
  end

  // R1 / R2: counter never passes the final piece of the latched sizing
  assert_cnt_range_R1: assert property (@(posedge clk) disable iff (!rst_n)
    loaded |-> (cnt <= last_idx));

  // R5: a non-final acceptance advances by one and keeps the word
  assert_step_no_pop_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (piece_accept && !last_accept) |=> (loaded && cnt == $past(cnt) + 1'b1));

  // R7: format held for the whole word
  assert_fmt_held_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && !last_accept) |=> $stable(fmt_q));

  // R8: first cycle out of reset holds nothing
  assert_reset_clear_R8: assert property (@(posedge clk)
    $rose(rst_n) |-> (!loaded && cnt == '0));

  // R10: empty FIFO is never popped
  assert_no_empty_pop_R10: assert property (@(posedge clk) disable iff (!rst_n)
    !src_valid |-> !src_pop);

endmodule

// File: rtl/unpk_mux.sv
module unpk_mux #(
  parameter int WIDE_W      = 36,
  parameter int NARROW_W    = 18,
  parameter int BYTE_W      = 9,
  parameter int WORD_PIECES = 2,
  parameter int BYTE_PIECES = 4,
  parameter int CNT_W       = 2
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic [WIDE_W-1:0]   hold,
  input  logic [CNT_W-1:0]    cnt,
  input  unpk_pkg::fmt_t      fmt_q,
  input  logic                loaded,
  output logic [NARROW_W-1:0] tx_data
);
  localparam int WSEL_W = (WORD_PIECES > 1) ? $clog2(WORD_PIECES) : 1;
  localparam int BSEL_W = (BYTE_PIECES > 1) ? $clog2(BYTE_PIECES) : 1;

  logic [NARROW_W-1:0] word_sl [WORD_PIECES];
  logic [BYTE_W-1:0]   byte_sl [BYTE_PIECES];
  logic [WSEL_W-1:0]   wsel;
  logic [BSEL_W-1:0]   bsel;

  for (genvar g = 0; g < WORD_PIECES; g++) begin : g_word
    assign word_sl[g] = hold[g*NARROW_W +: NARROW_W];
  end
  for (genvar g = 0; g < BYTE_PIECES; g++) begin : g_byte
    assign byte_sl[g] = hold[g*BYTE_W +: BYTE_W];
  end

  always_comb begin
    wsel = WSEL_W'(unpk_pkg::slot_of(int'(cnt), WORD_PIECES - 1, fmt_q.little));
    bsel = BSEL_W'(unpk_pkg::slot_of(int'(cnt), BYTE_PIECES - 1, fmt_q.little));
    if (fmt_q.byte_mode)
      tx_data = {{(NARROW_W-BYTE_W){1'b0}}, byte_sl[bsel]};
    else
      tx_data = word_sl[wsel];
  end

  // R2: upper lane is quiet in byte sizing
  assert_byte_upper_zero_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (loaded && fmt_q.byte_mode) |-> (tx_data[NARROW_W-1:BYTE_W] == '0));

endmodule

// File: rtl/bus_unpacker.sv
module bus_unpacker #(
  parameter int WIDE_W   = 36,
  parameter int NARROW_W = 18,
  parameter int BYTE_W   = 9
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                cfg_byte_mode,
  input  logic                cfg_little_endian,
  input  logic                src_valid,
  input  logic [WIDE_W-1:0]   src_data,
  output logic                src_pop,
  output logic                tx_valid,
  input  logic                tx_ready,
  output logic [NARROW_W-1:0] tx_data
);
  localparam int WORD_PIECES = WIDE_W / NARROW_W;
  localparam int BYTE_PIECES = WIDE_W / BYTE_W;
  localparam int CNT_W       = (BYTE_PIECES > 1) ? $clog2(BYTE_PIECES) : 1;

  logic [WIDE_W-1:0] hold;
  logic              loaded;
  logic [CNT_W-1:0]  cnt;
  unpk_pkg::fmt_t    fmt_q;
  logic              piece_accept;
  logic              last_accept;

  unpk_ctrl #(
    .WORD_PIECES(WORD_PIECES), .BYTE_PIECES(BYTE_PIECES), .CNT_W(CNT_W)
  ) u_ctrl (
    .clk(clk), .rst_n(rst_n),
    .cfg_byte_mode(cfg_byte_mode), .cfg_little_endian(cfg_little_endian),
    .src_valid(src_valid), .tx_ready(tx_ready),
    .src_pop(src_pop), .loaded(loaded), .cnt(cnt), .fmt_q(fmt_q),
    .piece_accept(piece_accept), .last_accept(last_accept)
  );

  always_ff @(posedge clk) begin
    if (!rst_n)       hold <= '0;
    else if (src_pop) hold <= src_data;
  end

  unpk_mux #(
    .WIDE_W(WIDE_W), .NARROW_W(NARROW_W), .BYTE_W(BYTE_W),
    .WORD_PIECES(WORD_PIECES), .BYTE_PIECES(BYTE_PIECES), .CNT_W(CNT_W)
  ) u_mux (
    .clk(clk), .rst_n(rst_n), .hold(hold), .cnt(cnt), .fmt_q(fmt_q),
    .loaded(loaded), .tx_data(tx_data)
  );

  assign tx_valid = loaded;

  // R6: a stalled piece stays put
  assert_stall_hold_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_valid && !tx_ready) |=> (tx_valid && $stable(tx_data)));

  // R9: final acceptance with data waiting refills without a bubble
  assert_no_bubble_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (last_accept && src_valid) |=> tx_valid);

endmodule

// File: tb/bus_unpacker_tb.sv
module bus_unpacker_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cfg_byte_mode = 1'b0;
  logic        cfg_little_endian = 1'b0;
  logic        src_valid;
  logic [35:0] src_data;
  logic        src_pop;
  logic        tx_valid;
  logic        tx_ready = 1'b0;
  logic [17:0] tx_data;

  always #2.5 clk = ~clk;

  bus_unpacker u_dut (
    .clk(clk), .rst_n(rst_n), .cfg_byte_mode(cfg_byte_mode),
    .cfg_little_endian(cfg_little_endian), .src_valid(src_valid),
    .src_data(src_data), .src_pop(src_pop), .tx_valid(tx_valid),
    .tx_ready(tx_ready), .tx_data(tx_data)
  );

  // FIFO model
  logic [35:0] fmem [64];
  int wr_p = 0;
  int rd_p = 0;
  assign src_valid = (wr_p != rd_p);
  assign src_data  = fmem[rd_p % 64];
  always @(posedge clk) if (src_pop) rd_p <= rd_p + 1;

  // cycle counter and receive log
  int cyc = 0;
  always @(posedge clk) cyc <= cyc + 1;
  logic [17:0] rx_d [256];
  int          rx_c [256];
  int          rx_n = 0;
  always @(negedge clk)
    if (rst_n && tx_valid && tx_ready) begin
      rx_d[rx_n % 256] = tx_data;
      rx_c[rx_n % 256] = cyc;
      rx_n++;
    end

  int tests = 0;
  int fails = 0;

  task automatic chk(bit ok, string req, logic [35:0] act, logic [35:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(int n);
    repeat (n) @(posedge clk);
    #1;
  endtask

  task automatic push(logic [35:0] w);
    fmem[wr_p % 64] = w;
    wr_p++;
  endtask

  task automatic pulse_ready();
    tx_ready = 1'b1;
    tick(1);
    tx_ready = 1'b0;
  endtask

  // expected piece k of word w
  function automatic logic [17:0] exp_piece(logic [35:0] w, bit bm, bit le, int k);
    logic [17:0] r;
    if (!bm) begin
      case ({le, k[0]})
        2'b00: r = w[35:18];
        2'b01: r = w[17:0];
        2'b10: r = w[17:0];
        default: r = w[35:18];
      endcase
    end else begin
      int b = le ? k : 3 - k;
      r = {9'd0, w[b*9 +: 9]};
    end
    return r;
  endfunction

  task automatic t_reset();
    @(negedge clk);
    chk(tx_valid == 1'b0, "R8 reset tx_valid", 36'(tx_valid), 0);
    chk(src_pop == 1'b0, "R10 empty no pop", 36'(src_pop), 0);
  endtask

  task automatic t_stream(bit bm, bit le, string req);
    logic [35:0] w [3];
    int np = bm ? 4 : 2;
    int base = rx_n;
    int guard = 0;
    w[0] = 36'h9_1234_5678 ^ {bm, le, 34'h0};
    w[1] = 36'hA_BCDE_F012;
    w[2] = 36'h5_0F0F_A5C3;
    cfg_byte_mode = bm;
    cfg_little_endian = le;
    tx_ready = 1'b1;
    for (int i = 0; i < 3; i++) push(w[i]);
    while (rx_n < base + 3*np && guard < 100) begin tick(1); guard++; end
    tick(2);
    chk(rx_n == base + 3*np, {req, " piece count"}, 36'(rx_n - base), 36'(3*np));
    for (int i = 0; i < 3*np; i++)
      chk(rx_d[(base+i)%256] == exp_piece(w[i/np], bm, le, i%np), req,
          36'(rx_d[(base+i)%256]), 36'(exp_piece(w[i/np], bm, le, i%np)));
    for (int i = 1; i < 3*np; i++)
      chk(rx_c[(base+i)%256] == rx_c[(base+i-1)%256] + 1, "R9 no bubble",
          36'(rx_c[(base+i)%256]), 36'(rx_c[(base+i-1)%256] + 1));
    @(negedge clk);
    chk(tx_valid == 1'b0, "R10 drained idle", 36'(tx_valid), 0);
    tx_ready = 1'b0;
    tick(1);
  endtask

  task automatic t_backpressure();
    logic [35:0] a = 36'hC_3355_AA11;
    logic [35:0] b = 36'h2_7788_9900;
    int r0 = rd_p;
    cfg_byte_mode = 1'b0;
    cfg_little_endian = 1'b0;
    tx_ready = 1'b0;
    push(a); push(b);
    tick(4);
    @(negedge clk);
    chk(tx_valid && tx_data == a[35:18], "R6 stall hold", 36'(tx_data), 36'(a[35:18]));
    chk(rd_p - r0 == 1, "R5 one pop while stalled", 36'(rd_p - r0), 1);
    tick(1);
    pulse_ready();
    tick(2);
    @(negedge clk);
    chk(tx_data == a[17:0], "R1 second half", 36'(tx_data), 36'(a[17:0]));
    chk(rd_p - r0 == 1, "R5 no pop mid word", 36'(rd_p - r0), 1);
    tick(1);
    pulse_ready();
    tick(1);
    @(negedge clk);
    chk(rd_p - r0 == 2, "R5 pop on final piece", 36'(rd_p - r0), 2);
    chk(tx_valid && tx_data == b[35:18], "R5 next word shown", 36'(tx_data), 36'(b[35:18]));
    tick(1);
    pulse_ready(); tick(1); pulse_ready(); tick(2);
  endtask

  task automatic t_midchange();
    logic [35:0] a = 36'h8_0001_FFFE;
    logic [35:0] b = 36'h1_2345_6789;
    cfg_byte_mode = 1'b0;
    cfg_little_endian = 1'b0;
    tx_ready = 1'b0;
    push(a); push(b);
    tick(3);
    pulse_ready();
    cfg_byte_mode = 1'b1;
    cfg_little_endian = 1'b1;
    tick(2);
    @(negedge clk);
    chk(tx_data == a[17:0], "R7 change ignored mid word", 36'(tx_data), 36'(a[17:0]));
    tick(1);
    pulse_ready();
    tick(1);
    @(negedge clk);
    chk(tx_data == {9'd0, b[8:0]}, "R7 change applied to next", 36'(tx_data), 36'({9'd0, b[8:0]}));
    tick(1);
    repeat (4) begin pulse_ready(); end
    tick(2);
  endtask

  task automatic t_reset_mid();
    logic [35:0] a = 36'h7_AAAA_5555;
    logic [35:0] b = 36'h3_1111_2222;
    cfg_byte_mode = 1'b0;
    cfg_little_endian = 1'b0;
    tx_ready = 1'b0;
    push(a);
    tick(3);
    pulse_ready();
    rst_n = 1'b0;
    tick(2);
    @(negedge clk);
    chk(tx_valid == 1'b0, "R8 reset drops valid", 36'(tx_valid), 0);
    rst_n = 1'b1;
    tick(3);
    @(negedge clk);
    chk(tx_valid == 1'b0, "R8 partial word gone", 36'(tx_valid), 0);
    tick(1);
    push(b);
    tick(2);
    @(negedge clk);
    chk(tx_valid && tx_data == b[35:18], "R8 counter restarts", 36'(tx_data), 36'(b[35:18]));
    tick(1);
    pulse_ready(); pulse_ready(); tick(2);
  endtask

  bit done = 1'b0;
  initial begin
    tick(3);
    t_reset();
    rst_n = 1'b1;
    tick(2);
    t_stream(1'b0, 1'b0, "R1 R3 word big");
    t_stream(1'b0, 1'b1, "R1 R4 word little");
    t_stream(1'b1, 1'b0, "R2 R3 byte big");
    t_stream(1'b1, 1'b1, "R2 R4 byte little");
    t_backpressure();
    t_midchange();
    t_reset_mid();
    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      tests++;
      fails++;
      $display("FAIL watchdog expired actual=%0d expected=done", cyc);
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end
endmodule